// File: doc/BRIEF.md
# Stopwatch and Reloading Interval Timer

This peripheral keeps two counters that advance on one shared time base. A prescaler divides the system clock into a tick, one for every `TICK_DIV` clocks (1536 by default). The first counter is a stopwatch, 12 bits wide by default. It counts ticks without stopping, wraps around, and returns to zero on any write to it. The second counter is an 8-bit interval timer. It counts down from a value that software loads, raises a pending interrupt flag each time it reaches zero, and then starts again from the same value.

Software reaches the block through a single write port. A select bit picks the register, and a byte strobe with a lane bit marks a narrow write. Both registers treat a narrow write as a full-word write, with the selected byte copied into both halves. The current stopwatch count and the stored reload value are always visible on output ports.

The interrupt line goes high only while the pending flag is set and the level-3 enable bit from the interrupt mask is set. Bit 3 of the mask register drives the `lvl3_enable` input. An acknowledge pulse clears the pending flag. Priority encoding across interrupt levels happens outside this block.

Top module: `tick_timer_pair`

## Requirements
- R1: A tick occurs once every `TICK_DIV` clocks. The first tick after reset falls on the `TICK_DIV`-th rising edge after `rst_n` goes high, and the prescaler phase is never disturbed by writes.
- R2: The stopwatch increments by one on each tick and wraps from 4095 to 0. With the default width it is 12 bits.
- R3: Any write to the stopwatch (`wr_sel` = 0) sets it to zero on the next edge, whatever the data, and takes precedence over a tick on the same edge.
- R4: A word write to the reload register (`wr_sel` = 1, `wr_byte` = 0) stores only `wr_data[7:0]`. The upper bits are discarded.
- R5: When the down-counter is zero, the next tick loads the reload value into it. That tick does not also decrement the counter.
- R6: On every other tick the counter decrements. The pending flag sets on the tick that brings the counter to zero, so interrupts repeat every reload+1 ticks.
- R7: With a reload value of zero the timer stays idle and never sets the pending flag.
- R8: `irq` is high only when the pending flag is set and `lvl3_enable` (bit 3 of the interrupt mask) is high. A flag raised while the enable is low appears as soon as the enable goes high.
- R9: A pulse on `irq_ack` clears the pending flag on the next edge. A flag set by a tick on that same edge wins.
- R10: For a byte write (`wr_byte` = 1), the byte is taken from `wr_data[15:8]` when `wr_hi_lane` = 1, otherwise from `wr_data[7:0]`. That byte is copied into both halves of a word, and the register handles the result as a word write.
- R11: Writing the reload register leaves the running count alone. The new value takes effect at the next load from zero.
- R12: After reset, the prescaler, stopwatch, down-counter and reload value are all zero, and the pending flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Target register: 0 stopwatch, 1 timer reload |
| wr_byte | input | 1 | Narrow write; the chosen byte is copied into both halves |
| wr_hi_lane | input | 1 | For a narrow write, take the byte from the upper lane |
| wr_data | input | BUS_W | Write data |
| lvl3_enable | input | 1 | Level-3 interrupt enable, bit 3 of the interrupt mask |
| irq_ack | input | 1 | Level-3 acknowledge; clears the pending flag |
| watch_value | output | WATCH_W | Current stopwatch count |
| reload_value | output | RELOAD_W | Stored timer reload value |
| irq | output | 1 | Level-3 interrupt request |

## Verification
The checker watches several rules on every cycle:
- The stopwatch moves only on a tick or a write, and only by a step of one.
- A stopwatch write always leaves zero.
- A word write to the reload register keeps exactly the low byte.
- An acknowledge without a coincident tick leaves the flag clear.
- `irq` can rise only after a tick or a rising enable.

Other behaviour depends on counting ticks, so only the directed scenarios can show it:
- the tick that is used up loading from zero;
- the reload+1 period;
- the idle state at reload zero;
- a reload change that waits for the next load;
- the lane copy in byte writes.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   // register select encoding seen on wr_sel
   typedef enum logic {
      TT_SEL_WATCH  = 1'b0,
      TT_SEL_RELOAD = 1'b1
   } tt_sel_e;

   // decoded write request for one cycle
   typedef struct packed {
      logic clr_watch;
      logic ld_reload;
   } tt_wreq_t;

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
   parameter int unsigned DIV = 1536
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
   localparam bit IS_POW2 = ((DIV & (DIV - 1)) == 0);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("tt_prescaler: DIV must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] phase;

   generate
      if (IS_POW2) begin : g_pow2
         // natural wrap of a full-width counter; no compare on the reload path
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) phase <= '0;
            else        phase <= phase + 1'b1;
         end
         assign tick = &phase;
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             phase <= '0;
            else if (phase == LAST) phase <= '0;
            else                    phase <= phase + 1'b1;
         end
         assign tick = (phase == LAST);
      end
   endgenerate

endmodule

// File: rtl/tt_stopwatch.sv
module tt_stopwatch #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         clr,
   output logic [W-1:0] value
);
   generate
      if (W < 1) begin : g_bad_w
         $error("tt_stopwatch: W must be positive");
      end
   endgenerate

   // a clear beats a coincident tick; wrap is the natural overflow of W bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= '0;
      else if (clr)  value <= '0;
      else if (tick) value <= value + 1'b1;
   end

endmodule

// File: rtl/tt_interval.sv
module tt_interval #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] reload,
   input  logic         ack,
   output logic         pending
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] count;
   logic         hit_zero;

   // the tick that decrements from one is the one that lands on zero
   assign hit_zero = tick && (count == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (tick) begin
         if (count == '0) count <= reload;       // load uses up this tick
         else             count <= count - 1'b1;
      end
   end

   // a new expiry outranks an acknowledge on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pending <= 1'b0;
      else if (hit_zero) pending <= 1'b1;
      else if (ack)      pending <= 1'b0;
   end

endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
   import tick_timer_pkg::*;
#(
   parameter int unsigned TICK_DIV = 1536,
   parameter int unsigned WATCH_W  = 12,
   parameter int unsigned RELOAD_W = 8,
   parameter int unsigned BUS_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_sel,
   input  logic                wr_byte,
   input  logic                wr_hi_lane,
   input  logic [BUS_W-1:0]    wr_data,
   input  logic                lvl3_enable,
   input  logic                irq_ack,
   output logic [WATCH_W-1:0]  watch_value,
   output logic [RELOAD_W-1:0] reload_value,
   output logic                irq
);
   localparam int unsigned LANE_W = BUS_W / 2;

   generate
      if ((BUS_W % 2) != 0) begin : g_bad_bus
         $error("tick_timer_pair: BUS_W must be even");
      end
      if (RELOAD_W > BUS_W || RELOAD_W < LANE_W) begin : g_bad_reload
         $error("tick_timer_pair: RELOAD_W must lie between BUS_W/2 and BUS_W");
      end
      if (WATCH_W > BUS_W) begin : g_bad_watch
         $error("tick_timer_pair: WATCH_W must not exceed BUS_W");
      end
   endgenerate

   tt_sel_e           sel;
   tt_wreq_t          wreq;
   logic [LANE_W-1:0] lane;
   logic [RELOAD_W-1:0] wr_eff;
   logic              tick;
   logic              pending;

   assign sel = tt_sel_e'(wr_sel);

   always_comb begin
      wreq.clr_watch = wr_en && (sel == TT_SEL_WATCH);
      wreq.ld_reload = wr_en && (sel == TT_SEL_RELOAD);
   end

   // narrow write: pick a lane and copy it across the word
   assign lane = wr_hi_lane ? wr_data[BUS_W-1:LANE_W] : wr_data[LANE_W-1:0];

   generate
      for (genvar i = 0; i < RELOAD_W; i++) begin : g_fill
         assign wr_eff[i] = wr_byte ? lane[i % LANE_W] : wr_data[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              reload_value <= '0;
      else if (wreq.ld_reload) reload_value <= wr_eff;
   end

   tt_prescaler #(.DIV(TICK_DIV)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   tt_stopwatch #(.W(WATCH_W)) u_watch (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .clr   (wreq.clr_watch),
      .value (watch_value)
   );

   tt_interval #(.W(RELOAD_W)) u_intv (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .reload  (reload_value),
      .ack     (irq_ack),
      .pending (pending)
   );

   assign irq = pending && lvl3_enable;

endmodule

// File: rtl/tick_timer_pair_chk.sv
module tick_timer_pair_chk #(
   parameter int unsigned WATCH_W  = 12,
   parameter int unsigned RELOAD_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic                wr_sel,
   input logic                wr_byte,
   input logic [RELOAD_W-1:0] data_lo,
   input logic                lvl3_enable,
   input logic                irq_ack,
   input logic [WATCH_W-1:0]  watch_value,
   input logic [RELOAD_W-1:0] reload_value,
   input logic                irq,
   input logic                tick,
   input logic                pending
);
   // R3
   watch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> (watch_value == '0));

   // R2
   watch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !wr_sel) |=> ((watch_value == $past(watch_value)) ||
                               (watch_value == WATCH_W'($past(watch_value) + 1'b1))));

   // R1
   watch_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !(wr_en && !wr_sel)) |=> $stable(watch_value));

   // R4
   reload_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && !wr_byte) |=> (reload_value == $past(data_lo)));

   // R9
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !tick) |=> !pending);

   // R8
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(tick) || $rose(lvl3_enable)));

endmodule

bind tick_timer_pair tick_timer_pair_chk #(
   .WATCH_W  (WATCH_W),
   .RELOAD_W (RELOAD_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_sel       (wr_sel),
   .wr_byte      (wr_byte),
   .data_lo      (wr_data[RELOAD_W-1:0]),
   .lvl3_enable  (lvl3_enable),
   .irq_ack      (irq_ack),
   .watch_value  (watch_value),
   .reload_value (reload_value),
   .irq          (irq),
   .tick         (tick),
   .pending      (pending)
);

// File: tb/tick_timer_pair_bench.sv
module tick_timer_pair_bench;
   localparam int DIV = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic        wr_byte = 1'b0;
   logic        wr_hi_lane = 1'b0;
   logic [15:0] wr_data = '0;
   logic        lvl3_enable = 1'b0;
   logic        irq_ack = 1'b0;
   logic [11:0] watch_value;
   logic [7:0]  reload_value;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tick_timer_pair #(.TICK_DIV(DIV)) u_tick_timer_pair (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_byte      (wr_byte),
      .wr_hi_lane   (wr_hi_lane),
      .wr_data      (wr_data),
      .lvl3_enable  (lvl3_enable),
      .irq_ack      (irq_ack),
      .watch_value  (watch_value),
      .reload_value (reload_value),
      .irq          (irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; irq_ack = 1'b0; lvl3_enable = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // returns at the negedge just after a tick edge
   task automatic sync_tick();
      logic [11:0] prev;
      prev = watch_value;
      do @(negedge clk); while (watch_value == prev);
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * DIV) @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic byt, input logic hi, input logic [15:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_byte = byt; wr_hi_lane = hi; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_byte = 1'b0; wr_hi_lane = 1'b0; wr_data = '0;
   endtask

   task automatic ack_pulse();
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic t_reset_and_rate();
      do_reset();
      lvl3_enable = 1'b1;
      chk("R12 watch after reset", watch_value, 0);
      chk("R12 reload after reset", reload_value, 0);
      chk("R12 irq after reset", irq, 0);
      repeat (DIV - 1) @(negedge clk);
      chk("R1 no tick before DIV edges", watch_value, 0);
      @(negedge clk);
      chk("R1 first tick on edge DIV", watch_value, 1);
      wait_ticks(1);
      chk("R1 second tick DIV later", watch_value, 2);
      wr(1'b1, 1'b0, 1'b0, 16'h0009);
      do_reset();
      chk("R12 reload cleared by reset", reload_value, 0);
   endtask

   task automatic t_watch();
      logic [11:0] s;
      do_reset();
      sync_tick();
      s = watch_value;
      wait_ticks(5);
      chk("R2 five ticks", watch_value, int'(s) + 5);
      wr(1'b0, 1'b0, 1'b0, 16'hFFFF);
      chk("R3 write clears", watch_value, 0);
      sync_tick();
      chk("R2 counts after clear", watch_value, 1);
      wait_ticks(4094);
      chk("R2 reaches top", watch_value, 4095);
      wait_ticks(1);
      chk("R2 wraps to zero", watch_value, 0);
   endtask

   task automatic t_regs();
      do_reset();
      wr(1'b1, 1'b0, 1'b0, 16'h1234);
      chk("R4 low byte kept", reload_value, 8'h34);
      wr(1'b1, 1'b1, 1'b1, 16'hA700);
      chk("R10 upper lane copied", reload_value, 8'hA7);
      wr(1'b1, 1'b1, 1'b0, 16'h335C);
      chk("R10 lower lane used", reload_value, 8'h5C);
      sync_tick();
      wr(1'b0, 1'b1, 1'b1, 16'h0000);
      chk("R10 R3 byte write clears watch", watch_value, 0);
   endtask

   task automatic t_period();
      do_reset();
      lvl3_enable = 1'b1;
      sync_tick();
      wr(1'b1, 1'b0, 1'b0, 16'h0003);
      sync_tick();
      chk("R5 load tick raises nothing", irq, 0);
      wait_ticks(2);
      chk("R5 load tick not a decrement", irq, 0);
      wait_ticks(1);
      chk("R6 expiry at reload+1 ticks", irq, 1);
      ack_pulse();
      chk("R9 ack clears", irq, 0);
      sync_tick();
      wait_ticks(2);
      chk("R6 no early second expiry", irq, 0);
      wait_ticks(1);
      chk("R6 second expiry after reload+1", irq, 1);
   endtask

   task automatic t_reload_change();
      do_reset();
      lvl3_enable = 1'b1;
      sync_tick();
      wr(1'b1, 1'b0, 1'b0, 16'h0003);
      sync_tick();
      wr(1'b1, 1'b0, 1'b0, 16'h0001);
      chk("R11 new reload stored", reload_value, 1);
      sync_tick();
      wait_ticks(1);
      chk("R11 count undisturbed early", irq, 0);
      wait_ticks(1);
      chk("R11 old count expires", irq, 1);
      ack_pulse();
      sync_tick();
      chk("R11 new value loaded", irq, 0);
      wait_ticks(1);
      chk("R11 new period applies", irq, 1);
   endtask

   task automatic t_zero();
      do_reset();
      lvl3_enable = 1'b1;
      sync_tick();
      wr(1'b1, 1'b0, 1'b0, 16'h0100);
      wait_ticks(20);
      chk("R7 zero reload idle", irq, 0);
      sync_tick();
      wr(1'b1, 1'b0, 1'b0, 16'h0002);
      sync_tick();
      wr(1'b1, 1'b0, 1'b0, 16'h0000);
      sync_tick();
      wait_ticks(1);
      chk("R7 last expiry before idle", irq, 1);
      ack_pulse();
      wait_ticks(10);
      chk("R7 idle after zero reload", irq, 0);
   endtask

   task automatic t_mask();
      do_reset();
      lvl3_enable = 1'b0;
      sync_tick();
      wr(1'b1, 1'b0, 1'b0, 16'h0001);
      sync_tick();
      wait_ticks(1);
      chk("R8 masked pending hidden", irq, 0);
      lvl3_enable = 1'b1;
      @(negedge clk);
      chk("R8 pending shown on enable", irq, 1);
      lvl3_enable = 1'b0;
      @(negedge clk);
      chk("R8 hidden again", irq, 0);
      lvl3_enable = 1'b1;
      ack_pulse();
      chk("R9 ack clears pending", irq, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset_and_rate();
      t_watch();
      t_regs();
      t_period();
      t_reload_change();
      t_zero();
      t_mask();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule